// File: doc/BRIEF.md
# Gray-Level Segment Pulse Modulator

This block turns 4-bit pixel codes into on/off segment waveforms, one line period at a time. The line period is a fixed count of 45 slots. Each pixel code picks one of 16 gray levels. Each level has its own programmable pulse width of 0 to 45 slots, and the segment is driven for that many slots at the start of the line. Level 0 is white when its width is 0. The darkest level is the one whose width is 45.

An optional frame-rate-control setting spreads a level over a cycle of 3 or 4 frames. Each frame gets the integer share of the width, and the leftover slots go to the earliest frames of the cycle. Over a whole cycle the summed on-time equals the programmed width. A reverse setting inverts every segment, so white and dark swap with no change to the pixel data.

Settings arrive as a byte stream. Width writes, mode changes and reverse changes are all collected in shadow state. They reach the outputs only at the next line boundary, so no line is ever cut short or stretched partway through.

Top module: `gray_pwm_modulator`

## Requirements
- R1: While `rst` is high, `seg_on`, `line_start` and `frame_phase` are all 0. After reset every level width is 0, frame control is off and reverse is off, so all segments stay off for a whole line.
- R2: `line_start` pulses for one cycle every 45 cycles. It marks output slot 0 of a line.
- R3: With frame control off and reverse off, a segment whose pixel selects width W is 1 for output slots 0..W-1 of the line and 0 for the remaining slots.
- R4: A width write is two bytes. The first byte has bits [7:6]=2'b10 and the level in bits [3:0]. The second byte carries the width in bits [5:0], and its bits [7:6] are ignored. A lone byte with bits [7:6]=2'b00 has no effect.
- R5: A written width above 45 is stored as 45.
- R6: A mode byte has bits [7:6]=2'b01, with bits [1:0] = 00 for frame control off, 01 for a 3-frame cycle and 10 for a 4-frame cycle. `frame_phase` advances by one every 2 lines (LINES=2) and wraps modulo the cycle length. It stays at 0 when frame control is off.
- R7: With frame control over N frames, a line in phase f shows floor(W/N) slots, plus one more slot when f < W mod N. The total over N*LINES consecutive lines is LINES*W.
- R8: A mode byte with bits [1:0]=2'b11 is ignored, and the previous cycle length stays in force.
- R9: A byte with bits [7:6]=2'b11 sets reverse to bit 0. While reverse is on, each segment shows the inverse waveform: 0 for the first W slots, then 1. A width-0 code is therefore on for all 45 slots.
- R10: Width, mode and reverse changes take effect from the line that starts after the next line boundary. A line already in progress keeps its old waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| pix_codes | input | NSEG*4 | Pixel codes; segment i uses bits [4i+3:4i] |
| seg_on | output | NSEG | Segment drive, registered |
| line_start | output | 1 | High in output slot 0 of each line |
| frame_phase | output | 2 | Frame index within the rate-control cycle |

## Verification
The outputs are registered one stage behind the slot counter. Output slot k of a line is therefore visible in the cycle that is k cycles after `line_start`, and the bench counts slots from that pulse. Settings are committed on the last slot of a line. For this reason the bench waits for two further `line_start` pulses after any write before it measures. In the boundary test it writes mid-line on purpose, then expects the old waveform on the current line and the new one on the next line. Frame-control results are judged per line, using the reported phase, and also as a sum over a full N*LINES window, which does not depend on where the window starts.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

  typedef enum logic [1:0] {
    FRC_OFF = 2'b00,
    FRC_3   = 2'b01,
    FRC_4   = 2'b10,
    FRC_BAD = 2'b11
  } frc_e;

  localparam logic [1:0] TAG_NOP  = 2'b00;
  localparam logic [1:0] TAG_MODE = 2'b01;
  localparam logic [1:0] TAG_PAL  = 2'b10;
  localparam logic [1:0] TAG_REV  = 2'b11;

  // number of frames in one rate-control cycle
  function automatic logic [2:0] frc_len(input frc_e m);
    case (m)
      FRC_3:   return 3'd3;
      FRC_4:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // share of width w shown in frame f of the cycle
  function automatic logic [7:0] frc_share(input logic [7:0] w, input frc_e m,
                                           input logic [1:0] f);
    logic [7:0] q;
    logic [7:0] r;
    case (m)
      FRC_3: begin
        q = w / 8'd3;
        r = w % 8'd3;
      end
      FRC_4: begin
        q = w >> 2;
        r = {6'd0, w[1:0]};
      end
      default: begin
        q = w;
        r = 8'd0;
      end
    endcase
    return q + (({6'd0, f} < r) ? 8'd1 : 8'd0);
  endfunction

endpackage

// File: rtl/gsm_cmd_dec.sv
module gsm_cmd_dec
  import gsm_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter int WB     = 6,
  parameter int MAX_W  = 45
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_we,
  input  logic [7:0]                 cmd_byte,
  output logic [LEVELS-1:0][WB-1:0]  shadow,
  output frc_e                       mode,
  output logic                       rev
);
  localparam int LB = $clog2(LEVELS);

  logic          await_data;
  logic [LB-1:0] sel;
  logic [WB-1:0] raw_w;
  logic [WB-1:0] clamp_w;
  logic [1:0]    tag;

  assign tag     = cmd_byte[7:6];
  assign raw_w   = cmd_byte[WB-1:0];
  assign clamp_w = (raw_w > WB'(MAX_W)) ? WB'(MAX_W) : raw_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      await_data <= 1'b0;
      sel        <= '0;
      shadow     <= '0;
      mode       <= FRC_OFF;
      rev        <= 1'b0;
    end else if (cmd_we) begin
      if (await_data) begin
        shadow[sel] <= clamp_w;
        await_data  <= 1'b0;
      end else begin
        case (tag)
          TAG_PAL: begin
            sel        <= cmd_byte[LB-1:0];
            await_data <= 1'b1;
          end
          TAG_MODE: if (cmd_byte[1:0] != 2'b11) mode <= frc_e'(cmd_byte[1:0]);
          TAG_REV:  rev <= cmd_byte[0];
          default:  ;
        endcase
      end
    end
  end

  // R5: a stored width never exceeds the line length
  p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && await_data) |=> (shadow[$past(sel)] <= WB'(MAX_W)));

  // R8: the illegal mode code leaves the mode untouched
  p_bad_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !await_data && tag == TAG_MODE && cmd_byte[1:0] == 2'b11) |=> $stable(mode));

  // R4: a header byte is always followed by a data phase
  p_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !await_data && tag == TAG_PAL) |=> (await_data && $stable(shadow)));

endmodule

// File: rtl/gsm_line_timer.sv
module gsm_line_timer
  import gsm_pkg::*;
#(
  parameter int MAX_W = 45,
  parameter int LINES = 2,
  parameter int CB    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  frc_e          mode,
  output logic [CB-1:0] cnt,
  output logic          line_end,
  output logic [1:0]    frame,
  output logic [1:0]    frame_nx
);
  localparam int LCB = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LCB-1:0] line_cnt;
  logic           frame_end;
  logic [2:0]     len;

  assign line_end  = (cnt == CB'(MAX_W - 1));
  assign frame_end = line_end && (line_cnt == LCB'(LINES - 1));
  assign len       = frc_len(mode);

  always_comb begin
    frame_nx = frame;
    if (frame_end)
      frame_nx = (({1'b0, frame} + 3'd1) >= len) ? 2'd0 : frame + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      line_cnt <= '0;
      frame    <= '0;
    end else begin
      cnt <= line_end ? '0 : cnt + CB'(1);
      if (line_end)
        line_cnt <= (line_cnt == LCB'(LINES - 1)) ? '0 : line_cnt + LCB'(1);
      frame <= frame_nx;
    end
  end

  // R2: slot counter stays inside the line and restarts after the last slot
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < MAX_W);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (cnt == '0));

  // R6: after a frame boundary the phase is inside the cycle length
  p_frame_len_r6: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> ({1'b0, frame} < $past(len)));

endmodule

// File: rtl/gsm_level_table.sv
module gsm_level_table
  import gsm_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter int WB     = 6,
  parameter int MAX_W  = 45
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      line_end,
  input  logic [LEVELS-1:0][WB-1:0] shadow,
  input  frc_e                      mode,
  input  logic [1:0]                frame_nx,
  input  logic                      rev,
  output logic [LEVELS-1:0][WB-1:0] lvl_w,
  output logic                      rev_act
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_w   <= '0;
      rev_act <= 1'b0;
    end else if (line_end) begin
      for (int i = 0; i < LEVELS; i++)
        lvl_w[i] <= WB'(frc_share(8'(shadow[i]), mode, frame_nx));
      rev_act <= rev;
    end
  end

  // R10: the active table only moves on a line boundary
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> ($stable(lvl_w) && $stable(rev_act)));

  for (genvar g = 0; g < LEVELS; g++) begin : g_chk
    // R5: no active width beyond the line length
    p_entry_max_r5: assert property (@(posedge clk) disable iff (rst)
      lvl_w[g] <= WB'(MAX_W));
  end

endmodule

// File: rtl/gsm_seg_cmp.sv
module gsm_seg_cmp #(
  parameter int NSEG   = 8,
  parameter int LEVELS = 16,
  parameter int WB     = 6,
  parameter int CB     = 6,
  parameter int CODEB  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CB-1:0]                cnt,
  input  logic [LEVELS-1:0][WB-1:0]    lvl_w,
  input  logic                         rev_act,
  input  logic [NSEG-1:0][CODEB-1:0]   codes,
  output logic [NSEG-1:0]              seg_q
);
  localparam int MB = (WB > CB) ? WB : CB;

  logic [NSEG-1:0] hit;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign hit[i] = MB'(cnt) < MB'(lvl_w[codes[i]]);

    // R3: a zero-width code is never driven in normal sense
    p_zero_off_r3: assert property (@(posedge clk) disable iff (rst)
      (!rev_act && lvl_w[codes[i]] == '0) |=> !seg_q[i]);
    // R9: a zero-width code is always driven in reverse sense
    p_rev_full_r9: assert property (@(posedge clk) disable iff (rst)
      (rev_act && lvl_w[codes[i]] == '0) |=> seg_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= '0;
    else     seg_q <= hit ^ {NSEG{rev_act}};
  end

endmodule

// File: rtl/gray_pwm_modulator.sv
module gray_pwm_modulator
  import gsm_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int LEVELS = 16,
  parameter int WB     = 6,
  parameter int MAX_W  = 45,
  parameter int LINES  = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cmd_we,
  input  logic [7:0]                        cmd_byte,
  input  logic [NSEG*$clog2(LEVELS)-1:0]    pix_codes,
  output logic [NSEG-1:0]                   seg_on,
  output logic                              line_start,
  output logic [1:0]                        frame_phase
);
  localparam int CODEB = $clog2(LEVELS);
  localparam int CB    = $clog2(MAX_W);

  logic [LEVELS-1:0][WB-1:0] shadow;
  logic [LEVELS-1:0][WB-1:0] lvl_w;
  frc_e                      mode;
  logic                      rev;
  logic                      rev_act;
  logic [CB-1:0]             cnt;
  logic                      line_end;
  logic [1:0]                frame;
  logic [1:0]                frame_nx;
  logic [NSEG-1:0][CODEB-1:0] codes;

  assign codes = pix_codes;

  gsm_cmd_dec #(.LEVELS(LEVELS), .WB(WB), .MAX_W(MAX_W)) u_dec (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .shadow(shadow), .mode(mode), .rev(rev)
  );

  gsm_line_timer #(.MAX_W(MAX_W), .LINES(LINES), .CB(CB)) u_tmr (
    .clk(clk), .rst(rst), .mode(mode), .cnt(cnt), .line_end(line_end),
    .frame(frame), .frame_nx(frame_nx)
  );

  gsm_level_table #(.LEVELS(LEVELS), .WB(WB), .MAX_W(MAX_W)) u_tab (
    .clk(clk), .rst(rst), .line_end(line_end), .shadow(shadow), .mode(mode),
    .frame_nx(frame_nx), .rev(rev), .lvl_w(lvl_w), .rev_act(rev_act)
  );

  gsm_seg_cmp #(.NSEG(NSEG), .LEVELS(LEVELS), .WB(WB), .CB(CB), .CODEB(CODEB)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .lvl_w(lvl_w), .rev_act(rev_act),
    .codes(codes), .seg_q(seg_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_start  <= 1'b0;
      frame_phase <= 2'd0;
    end else begin
      line_start  <= (cnt == '0);
      frame_phase <= frame;
    end
  end

  // R2: line marker is a single-cycle pulse
  p_ls_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

endmodule

// File: tb/gray_pwm_modulator_bench.sv
module gray_pwm_modulator_bench;
  localparam int NSEG  = 8;
  localparam int LW    = 45;
  localparam int LINES = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmd_we;
  logic [7:0]        cmd_byte;
  logic [NSEG*4-1:0] pix;
  logic [NSEG-1:0]   seg_on;
  logic              line_start;
  logic [1:0]        frame_phase;

  int total = 0;
  int bad   = 0;
  int pal[16];
  int m_cnt[NSEG];
  bit m_shape[NSEG];
  int m_ph;
  bit rev_m;

  always #10 clk = ~clk;

  gray_pwm_modulator #(.NSEG(NSEG), .LINES(LINES)) u_gray_pwm_modulator (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte), .pix_codes(pix),
    .seg_on(seg_on), .line_start(line_start), .frame_phase(frame_phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int share(input int w, input int n, input int f);
    return (w / n) + ((f < (w % n)) ? 1 : 0);
  endfunction

  function automatic int code_of(input int s);
    return int'(pix[s*4 +: 4]);
  endfunction

  task automatic send_byte(input logic [7:0] b);
    cmd_byte = b;
    cmd_we   = 1'b1;
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic pal_write(input int lvl, input int val, input logic [1:0] junk);
    send_byte({2'b10, 2'b00, 4'(lvl)});
    send_byte({junk, 6'(val)});
    pal[lvl] = (val > LW) ? LW : val;
  endtask

  task automatic wait_ls();
    while (!line_start) @(negedge clk);
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wait_ls();
    end
  endtask

  // measures one line starting at the current (line_start) sample; ends on the next line start
  task automatic run_line();
    bit prev[NSEG];
    m_ph = int'(frame_phase);
    for (int s = 0; s < NSEG; s++) begin
      m_cnt[s] = 0;
      m_shape[s] = 1'b1;
    end
    for (int j = 0; j < LW; j++) begin
      if (j > 0) @(negedge clk);
      for (int s = 0; s < NSEG; s++) begin
        if (j > 0 && (rev_m ? (prev[s] && !seg_on[s]) : (!prev[s] && seg_on[s])))
          m_shape[s] = 1'b0;
        prev[s] = seg_on[s];
        m_cnt[s] += int'(seg_on[s]);
      end
    end
    @(negedge clk);
    check(line_start == 1'b1, "R2 line_start period", int'(line_start), 1);
  endtask

  task automatic check_plain(input string req);
    for (int s = 0; s < NSEG; s++) begin
      int e;
      e = rev_m ? LW - pal[code_of(s)] : pal[code_of(s)];
      check(m_cnt[s] == e, req, m_cnt[s], e);
      check(m_shape[s], {req, " shape"}, 0, 1);
    end
  endtask

  task automatic frc_run(input logic [1:0] field, input int n, input string req);
    int sum[NSEG];
    int prev_ph;
    if (field != 2'b00 || n == 1) send_byte({2'b01, 4'd0, field});
    settle(n * LINES + 3);
    for (int s = 0; s < NSEG; s++) sum[s] = 0;
    prev_ph = -1;
    for (int l = 0; l < n * LINES; l++) begin
      run_line();
      check(m_ph < n, {req, " R6 phase range"}, m_ph, n - 1);
      if (prev_ph >= 0 && m_ph != prev_ph)
        check(m_ph == (prev_ph + 1) % n, {req, " R6 phase step"}, m_ph, (prev_ph + 1) % n);
      prev_ph = m_ph;
      for (int s = 0; s < NSEG; s++) begin
        int e;
        e = share(pal[code_of(s)], n, m_ph);
        check(m_cnt[s] == e, {req, " R7 per-frame width"}, m_cnt[s], e);
        sum[s] += m_cnt[s];
      end
    end
    for (int s = 0; s < NSEG; s++)
      check(sum[s] == LINES * pal[code_of(s)], {req, " R7 cycle sum"}, sum[s],
            LINES * pal[code_of(s)]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int old_w;
    rst = 1'b1; cmd_we = 1'b0; cmd_byte = 8'h00; pix = '0; rev_m = 1'b0;
    for (int i = 0; i < 16; i++) pal[i] = 0;
    void'($urandom(32'h1c3d5));
    repeat (4) @(negedge clk);
    check(seg_on == '0, "R1 seg in reset", int'(seg_on), 0);
    check(line_start == 1'b0 && frame_phase == 2'd0, "R1 marks in reset",
          int'({line_start, frame_phase}), 0);
    rst = 1'b0;
    pix = {NSEG*4{1'b1}};
    @(negedge clk);
    wait_ls();
    run_line();
    check_plain("R1 widths zero after reset");

    // directed and random widths
    pal_write(0, 0, 2'b00);
    pal_write(15, 45, 2'b00);
    pal_write(1, 63, 2'b00);
    pal_write(2, 46, 2'b11);
    pal_write(3, 44, 2'b01);
    pal_write(4, 1, 2'b00);
    pal_write(5, 7, 2'b10);
    pal_write(6, 10, 2'b00);
    pal_write(7, 11, 2'b00);
    for (int i = 8; i < 15; i++) pal_write(i, $urandom_range(0, 63), 2'(i));
    check(pal[1] == 45 && pal[2] == 45, "R5 model clamp", pal[1], 45);

    pix = {4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
    settle(2);
    run_line();
    check_plain("R3 R5 directed widths");
    pix = {4'd15, 4'd14, 4'd13, 4'd12, 4'd11, 4'd10, 4'd9, 4'd8};
    settle(2);
    run_line();
    check_plain("R3 R4 upper levels");
    for (int p = 0; p < 3; p++) begin
      pix = NSEG*4'($urandom());
      settle(2);
      run_line();
      check_plain("R3 random codes");
    end

    // no-op byte leaves everything as is
    send_byte(8'h2A);
    settle(2);
    run_line();
    check_plain("R4 no-op byte");

    // frame rate control
    pix = {4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd15, 4'd1, 4'd0};
    frc_run(2'b01, 3, "R6 3-frame");
    frc_run(2'b10, 4, "R6 4-frame");
    send_byte(8'h43);
    frc_run(2'b00, 4, "R8 illegal mode kept 4-frame");
    frc_run(2'b00, 1, "R6 control off");

    // reverse sense
    send_byte(8'hC1);
    rev_m = 1'b1;
    settle(2);
    run_line();
    check_plain("R9 reverse");
    check(m_cnt[0] == LW, "R9 width0 full on", m_cnt[0], LW);
    send_byte(8'hC0);
    rev_m = 1'b0;
    settle(2);
    run_line();
    check_plain("R9 reverse off");

    // mid-line write applies from the next line
    settle(1);
    old_w = pal[0];
    fork
      run_line();
      begin
        repeat (10) @(negedge clk);
        pal_write(0, 30, 2'b00);
      end
    join
    check(m_cnt[0] == old_w, "R10 current line keeps old width", m_cnt[0], old_w);
    run_line();
    check(m_cnt[0] == 30, "R10 next line has new width", m_cnt[0], 30);
    run_line();
    check_plain("R10 after update");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule